// File: doc/BRIEF.md
# Serial Four-Mode CRC-16 Engine

This block computes a 16-bit cyclic redundancy check one bit at a time over the data bits of a serial character stream. A UART transmitter and receiver share it. The transmit side presents each data bit with a valid strobe and then appends the check word the engine offers. The receive side feeds every data bit, including the received check word, and raises a frame-end strobe on the last bit. The engine then records whether the final remainder matches the residue that a good frame leaves. The framing logic around the engine excludes start, parity and stop bits by not strobing them in.

A two-bit mode selects one of two polynomials and one of two preset values. Bits are taken least significant first, so each polynomial is used in reflected form. The mode is captured when the preset strobe fires and stays in force until the next preset. Only the mode that uses the CCITT polynomial with an all-ones preset inverts the transmitted check word and expects a nonzero receive residue. The running remainder is always visible, so a host can read it at any time.

Top module: `crc_serial_engine`

## Requirements
- R1: After reset the remainder is 0x0000, the transmit check word is 0x0000, the error flag is 0 and the captured mode is 0.
- R2: A preset strobe captures `mode_sel` and loads the remainder with 0x0000 for modes 0 and 2, or with 0xFFFF for modes 1 and 3, on the next clock edge.
- R3: Each valid data bit advances the remainder one step, least significant bit first. The feedback is remainder bit 0 XOR the data bit. The remainder shifts right by one and, when the feedback is 1, is XORed with 0xA001 in modes 0 and 1 or with 0x8408 in modes 2 and 3.
- R4: When neither preset nor bit valid is asserted, the remainder does not change.
- R5: The check word equals the remainder in modes 0, 1 and 2, and equals the bitwise inverse of the remainder in mode 3. Over the ASCII string "123456789" the check word is 0xBB3D, 0x4B37, 0x2189 and 0x906E for modes 0 to 3.
- R6: A frame-end strobe sets the error flag to 1 if the remainder, including any bit absorbed in that same cycle, differs from the mode's residue. The residue is 0x0000 in modes 0 to 2 and 0xF0B8 in mode 3. Otherwise the strobe sets the flag to 0.
- R7: A preset clears the error flag. A preset takes priority over a data bit and over a frame-end strobe in the same cycle, and those other strobes have no effect in that cycle.
- R8: The error flag keeps its value in every cycle without a preset or frame-end strobe.
- R9: In every mode, a frame whose data is followed by its check word, sent low byte first and each byte least significant bit first, ends with the error flag at 0.
- R10: Changes on `mode_sel` between presets have no effect on the polynomial, the check word or the residue in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Mode requested, captured on preset |
| preset | input | 1 | Reload the mode's preset value and clear the error flag |
| bit_valid | input | 1 | Data bit on `bit_in` enters the CRC this cycle |
| bit_in | input | 1 | Serial data bit |
| frame_end | input | 1 | Compare the remainder with the residue this cycle |
| remainder | output | 16 | Running remainder |
| tx_check | output | 16 | Check word for the transmitter to append |
| crc_err | output | 1 | Receive check failed at the last frame end |

## Verification
The final data bit and the frame-end comparison can occur in the same cycle. A frame that ends correctly only passes if the comparison sees the remainder after that last bit has been absorbed. The bench ends every appended-check frame by raising `frame_end` together with the last check bit. It then expects a clear flag, and a set flag for a frame with one bit corrupted. A preset that coincides with a data bit or with a frame-end strobe is also driven. The bench expects the preset value and a cleared flag, which shows that the other strobe was dropped.

// File: rtl/crc_serial_pkg.sv
package crc_serial_pkg;

    localparam int CRC_W = 16;

    typedef enum logic [1:0] {
        MODE_A16_ZERO = 2'd0,
        MODE_A16_ONES = 2'd1,
        MODE_CC_ZERO  = 2'd2,
        MODE_CC_ONES  = 2'd3
    } crc_mode_e;

    typedef struct packed {
        logic [CRC_W-1:0] poly;
        logic [CRC_W-1:0] residue;
        logic             invert;
    } mode_cfg_t;

    typedef struct packed {
        logic [CRC_W-1:0] rem;
        crc_mode_e        mode;
        logic             err;
    } crc_state_t;

    function automatic logic [CRC_W-1:0] preset_value(input crc_mode_e m);
        return m[0] ? {CRC_W{1'b1}} : {CRC_W{1'b0}};
    endfunction

endpackage

// File: rtl/crc_mode_table.sv
module crc_mode_table
    import crc_serial_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY_A16   = 16'hA001,
    parameter logic [CRC_W-1:0] POLY_CC    = 16'h8408,
    parameter logic [CRC_W-1:0] RESIDUE_CC = 16'hF0B8
) (
    input  crc_mode_e mode,
    output mode_cfg_t cfg
);

    always_comb begin
        cfg.poly    = mode[1] ? POLY_CC : POLY_A16;
        cfg.invert  = (mode == MODE_CC_ONES);
        cfg.residue = (mode == MODE_CC_ONES) ? RESIDUE_CC : {CRC_W{1'b0}};
    end

endmodule

// File: rtl/crc_bit_step.sv
module crc_bit_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] rem_in,
    input  logic [W-1:0] poly,
    input  logic         enable,
    input  logic         din,
    output logic [W-1:0] rem_out
);

    logic         feedback;
    logic [W-1:0] shifted;

    always_comb begin
        feedback = rem_in[0] ^ din;
        shifted  = rem_in >> 1;
        if (!enable) begin
            rem_out = rem_in;
        end else if (feedback) begin
            rem_out = shifted ^ poly;
        end else begin
            rem_out = shifted;
        end
    end

endmodule

// File: rtl/crc_serial_engine.sv
module crc_serial_engine
    import crc_serial_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_sel,
    input  logic             preset,
    input  logic             bit_valid,
    input  logic             bit_in,
    input  logic             frame_end,
    output logic [CRC_W-1:0] remainder,
    output logic [CRC_W-1:0] tx_check,
    output logic             crc_err
);

    crc_state_t       state_d, state_q;
    mode_cfg_t        cfg_cur;
    logic [CRC_W-1:0] rem_step;

    crc_mode_table i_table (
        .mode (state_q.mode),
        .cfg  (cfg_cur)
    );

    crc_bit_step #(.W(CRC_W)) i_step (
        .rem_in  (state_q.rem),
        .poly    (cfg_cur.poly),
        .enable  (bit_valid),
        .din     (bit_in),
        .rem_out (rem_step)
    );

    always_comb begin
        state_d = state_q;
        if (preset) begin
            state_d.mode = crc_mode_e'(mode_sel);
            state_d.rem  = preset_value(crc_mode_e'(mode_sel));
            state_d.err  = 1'b0;
        end else begin
            state_d.rem = rem_step;
            if (frame_end) begin
                state_d.err = (rem_step != cfg_cur.residue);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{rem: '0, mode: MODE_A16_ZERO, err: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    assign remainder = state_q.rem;
    assign tx_check  = cfg_cur.invert ? ~state_q.rem : state_q.rem;
    assign crc_err   = state_q.err;

    AST_PRESET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        preset |=> remainder == ($past(mode_sel[0]) ? 16'hFFFF : 16'h0000)); // R2

    AST_REM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!preset && !bit_valid) |=> $stable(remainder)); // R4

    AST_PRESET_CLEARS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        preset |=> !crc_err); // R7

    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!preset && !frame_end) |=> $stable(crc_err)); // R8

    AST_TX_STABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!preset && !bit_valid) |=> $stable(tx_check)); // R10

endmodule

// File: tb/test_crc_serial_engine.sv
`timescale 1ns/1ps
module test_crc_serial_engine;

    typedef struct {
        logic [15:0] rem;
        logic [15:0] tx;
        logic        err;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_sel = 2'd0;
    logic        preset = 1'b0;
    logic        bit_valid = 1'b0;
    logic        bit_in = 1'b0;
    logic        frame_end = 1'b0;
    logic [15:0] remainder;
    logic [15:0] tx_check;
    logic        crc_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;
    exp_t sb_q[$];

    logic [15:0] m_rem  = 16'h0;
    logic [1:0]  m_mode = 2'd0;
    logic        m_err  = 1'b0;

    always #2 clk = ~clk;

    crc_serial_engine i_crc_serial_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_sel  (mode_sel),
        .preset    (preset),
        .bit_valid (bit_valid),
        .bit_in    (bit_in),
        .frame_end (frame_end),
        .remainder (remainder),
        .tx_check  (tx_check),
        .crc_err   (crc_err)
    );

    function automatic logic [15:0] ref_step(logic [15:0] r, logic [1:0] m, logic b);
        logic fb;
        fb = r[0] ^ b;
        r  = r >> 1;
        if (fb) r = r ^ (m[1] ? 16'h8408 : 16'hA001);
        return r;
    endfunction

    function automatic logic [15:0] ref_tx(logic [15:0] r, logic [1:0] m);
        return (m == 2'd3) ? ~r : r;
    endfunction

    task automatic check16(string tag, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=0x%04h expected=0x%04h", tag, act, exp);
        end
    endtask

    // driver: one cycle of stimulus, expected result pushed to the scoreboard
    task automatic step(logic pre, logic [1:0] md, logic bv, logic b, logic fe, string tag);
        logic [15:0] nr;
        @(negedge clk);
        preset = pre; mode_sel = md; bit_valid = bv; bit_in = b; frame_end = fe;
        if (pre) begin
            m_mode = md;
            m_rem  = md[0] ? 16'hFFFF : 16'h0000;
            m_err  = 1'b0;
        end else begin
            nr = bv ? ref_step(m_rem, m_mode, b) : m_rem;
            if (fe) m_err = (nr != ((m_mode == 2'd3) ? 16'hF0B8 : 16'h0000));
            m_rem = nr;
        end
        @(posedge clk);
        sb_q.push_back('{rem: m_rem, tx: ref_tx(m_rem, m_mode), err: m_err, tag: tag});
        #1;
        preset = 1'b0; bit_valid = 1'b0; frame_end = 1'b0;
    endtask

    task automatic send_byte(logic [7:0] v, logic [1:0] md_pins, logic fe_last, string tag);
        for (int i = 0; i < 8; i++) begin
            step(1'b0, md_pins, 1'b1, v[i], fe_last && (i == 7), tag);
        end
    endtask

    task automatic send_digits(logic [1:0] md_pins, string tag);
        for (int k = 1; k <= 9; k++) begin
            send_byte(8'h30 + 8'(k), md_pins, 1'b0, tag);
        end
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    // monitor: compares design outputs against queued expectations
    always @(negedge clk) begin
        #1;
        if (sb_q.size() != 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check16({e.tag, " remainder"}, remainder, e.rem);
            check16({e.tag, " tx_check"},  tx_check,  e.tx);
            check16({e.tag, " crc_err"},   {15'd0, crc_err}, {15'd0, e.err});
        end
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] chk;
        logic [15:0] known [4];
        known[0] = 16'hBB3D; known[1] = 16'h4B37; known[2] = 16'h2189; known[3] = 16'h906E;

        repeat (3) @(posedge clk);
        settle();
        // R1 reset state
        check16("R1 remainder", remainder, 16'h0000);
        check16("R1 tx_check", tx_check, 16'h0000);
        check16("R1 crc_err", {15'd0, crc_err}, 16'h0000);
        rst_n = 1'b1;

        for (int md = 0; md < 4; md++) begin
            // R2 preset, R3 stepping, R5 known check words
            step(1'b1, 2'(md), 1'b0, 1'b0, 1'b0, "R2 preset");
            send_digits(2'(md), "R3 step");
            settle();
            check16("R5 known check word", tx_check, known[md]);
            chk = ref_tx(m_rem, m_mode);
            // R9 append check low byte first, R6 frame_end with last bit
            send_byte(chk[7:0], 2'(md), 1'b0, "R9 append lo");
            send_byte(chk[15:8], 2'(md), 1'b1, "R9 R6 append hi");
            settle();
            check16("R9 good frame err", {15'd0, crc_err}, 16'h0000);
            if (md == 3) check16("R6 residue mode 3", remainder, 16'hF0B8);
            else         check16("R6 residue zero", remainder, 16'h0000);
            // R4 / R8 idle cycles hold
            repeat (3) step(1'b0, 2'(md), 1'b0, 1'b1, 1'b0, "R4 R8 idle");
        end

        // R6 corrupted frame
        step(1'b1, 2'd3, 1'b0, 1'b0, 1'b0, "R2 preset");
        send_digits(2'd3, "R3 step");
        chk = ref_tx(m_rem, m_mode) ^ 16'h0010;
        send_byte(chk[7:0], 2'd3, 1'b0, "R6 bad lo");
        send_byte(chk[15:8], 2'd3, 1'b1, "R6 bad hi");
        settle();
        check16("R6 corrupted err", {15'd0, crc_err}, 16'h0001);
        repeat (2) step(1'b0, 2'd0, 1'b0, 1'b0, 1'b0, "R8 err holds");

        // R7 preset with frame_end in same cycle: err cleared, remainder preset
        step(1'b1, 2'd1, 1'b0, 1'b0, 1'b1, "R7 preset+frame_end");
        // R7 preset with bit in same cycle: bit dropped
        step(1'b1, 2'd0, 1'b1, 1'b1, 1'b0, "R7 preset+bit");
        settle();
        check16("R7 bit dropped", remainder, 16'h0000);

        // R10 mode pins change mid-frame: captured mode 2 stays in force
        step(1'b1, 2'd2, 1'b0, 1'b0, 1'b0, "R2 preset");
        send_digits(2'd1, "R10 pins moved");
        settle();
        check16("R10 mode kept", tx_check, 16'h2189);
        chk = ref_tx(m_rem, m_mode);
        send_byte(chk[7:0], 2'd3, 1'b0, "R10 append lo");
        send_byte(chk[15:8], 2'd3, 1'b1, "R10 append hi");
        settle();
        check16("R10 residue unchanged", {15'd0, crc_err}, 16'h0000);

        // R7 preset of mode 3 then idle, then frame_end alone on preset value
        step(1'b1, 2'd3, 1'b0, 1'b0, 1'b0, "R2 preset ones");
        step(1'b0, 2'd0, 1'b0, 1'b0, 1'b1, "R6 frame_end no bit");
        settle();
        check16("R6 nonresidue err", {15'd0, crc_err}, 16'h0001);

        repeat (2) settle();
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule